// File: doc/BRIEF.md
# Arithmetic Right Shifter with Lost-Bit Carry

This block shifts a signed 32-bit word to the right and fills the vacated positions with copies of the sign bit. The shift distance comes from a full-width amount register. Only the low six bits of that register matter. Bits 0 to 4 give the distance, and bit 5 marks an over-range request.

An over-range request does not wrap. It saturates to a word made entirely of sign bits. Alongside the result the block raises a carry flag. The flag says that a negative operand lost at least one 1 bit. A consumer can use it to correct a shift-based divide of a negative number toward zero.

The datapath is combinational. A build parameter can place a register stage behind it. In that mode a valid strobe is passed along one cycle late, and result and carry are captured together only on valid input cycles.

Top module: `sras_unit`

## Requirements
- R1: With amount bit 5 clear, the result equals the operand shifted right by amount bits 4..0, with every vacated upper bit equal to operand bit 31.
- R2: With amount bit 5 clear, the carry is 1 exactly when operand bit 31 is 1 and at least one bit shifted out below bit 0 was 1; a non-negative operand never sets it.
- R3: An amount whose low six bits are zero returns the operand unchanged with carry 0.
- R4: With amount bit 5 set (effective amounts 32 to 63), all 32 result bits equal operand bit 31.
- R5: With amount bit 5 set, the carry is 1 exactly when operand bit 31 is 1 and any of operand bits 30..0 is 1.
- R6: Amount bits 31..6 have no effect on the result or the carry.
- R7: In registered mode, out_valid in each cycle equals in_valid of the previous cycle.
- R8: In registered mode, result and carry are captured together in the cycle after an in_valid cycle, and both hold their values while in_valid is low.
- R9: While rst_n is low, out_valid, out_result and out_carry are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and amount are presented this cycle |
| in_value | input | 32 | Signed operand to shift |
| in_amount | input | 32 | Amount register; only bits 5..0 are used |
| out_valid | output | 1 | Result strobe (one cycle late when registered) |
| out_result | output | 32 | Shifted, sign-filled result |
| out_carry | output | 1 | Negative operand lost a 1 bit |

## Verification
Saturation and the carry decision meet in the same cycle whenever amount bit 5 is set on a negative operand. In that case the fill path and the over-range carry rule must agree on one captured word. The bench provokes this with amounts 32, 40 and 63 on values that hold only the sign bit and on values that also hold low bits. A cycle-accurate behavioural model predicts the captured pair and compares it on every clock, including the cycles where in_valid is low and both outputs must hold. The bench also sweeps random operands across in-range and over-range amounts with junk in amount bits 31..6.

// File: rtl/sras_pkg.sv
package sras_pkg;

  // Output staging variant selected at build time
  typedef enum logic {
    SRAS_OUT_COMB = 1'b0,
    SRAS_OUT_REG  = 1'b1
  } sras_out_mode_e;

  localparam int SRAS_DEF_DATA_W = 32;
  localparam int SRAS_DEF_AMT_W  = 32;

endpackage

// File: rtl/sras_barrel.sv
// Logarithmic right shifter with sign fill; reports whether any 1 bit
// fell off the low end in any stage.
module sras_barrel #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = 5
) (
  input  logic [DATA_W-1:0]  value,
  input  logic [SHAMT_W-1:0] amt,
  output logic [DATA_W-1:0]  shifted,
  output logic               lost_any
);

  logic [DATA_W-1:0]  stg [SHAMT_W+1];
  logic [SHAMT_W-1:0] lost_vec;
  logic               sign_b;

  assign sign_b = value[DATA_W-1];
  assign stg[0] = value;

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [DATA_W-1:0] moved;
    assign moved       = {{STEP{sign_b}}, stg[k][DATA_W-1:STEP]};
    assign stg[k+1]    = amt[k] ? moved : stg[k];
    assign lost_vec[k] = amt[k] & (|stg[k][STEP-1:0]);
  end

  assign shifted  = stg[SHAMT_W];
  assign lost_any = |lost_vec;

endmodule

// File: rtl/sras_resolve.sv
// Chooses between the in-range shift and sign saturation, and forms
// the carry for both cases.
module sras_resolve #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] shifted,
  input  logic              lost_any,
  input  logic              over,
  output logic [DATA_W-1:0] result,
  output logic              carry
);

  logic sign_b;
  logic body_nz;

  assign sign_b  = value[DATA_W-1];
  assign body_nz = |value[DATA_W-2:0];

  always_comb begin
    if (over) begin
      result = {DATA_W{sign_b}};
      carry  = sign_b & body_nz;
    end else begin
      result = shifted;
      carry  = sign_b & lost_any;
    end
  end

endmodule

// File: rtl/sras_out_stage.sv
// Optional capture stage: result and carry share one enable.
module sras_out_stage
  import sras_pkg::*;
#(
  parameter int             DATA_W   = 32,
  parameter sras_out_mode_e OUT_MODE = SRAS_OUT_REG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] res_d,
  input  logic              carry_d,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_carry
);

  if (OUT_MODE == SRAS_OUT_REG) begin : g_reg
    logic              vld_q, vld_n;
    logic [DATA_W-1:0] res_q, res_n;
    logic              ca_q, ca_n;
    logic              cap_en;

    assign cap_en = in_valid;

    always_comb begin
      vld_n = in_valid;
      res_n = res_q;
      ca_n  = ca_q;
      if (cap_en) begin
        res_n = res_d;
        ca_n  = carry_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        res_q <= '0;
        ca_q  <= 1'b0;
      end else begin
        vld_q <= vld_n;
        res_q <= res_n;
        ca_q  <= ca_n;
      end
    end

    assign out_valid  = vld_q;
    assign out_result = res_q;
    assign out_carry  = ca_q;
  end else begin : g_comb
    logic unused_clkrst;
    assign unused_clkrst = clk ^ rst_n;
    assign out_valid  = in_valid;
    assign out_result = res_d;
    assign out_carry  = carry_d;
  end

endmodule

// File: rtl/sras_unit.sv
module sras_unit
  import sras_pkg::*;
#(
  parameter int             DATA_W   = SRAS_DEF_DATA_W,
  parameter int             AMT_W    = SRAS_DEF_AMT_W,
  parameter sras_out_mode_e OUT_MODE = SRAS_OUT_REG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_value,
  input  logic [AMT_W-1:0]  in_amount,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_carry
);

  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int OVER_B  = SHAMT_W;

  logic [SHAMT_W-1:0] amt_lo;
  logic               amt_over;
  logic               amt_unused_hi;
  logic [DATA_W-1:0]  shifted;
  logic               lost_any;
  logic [DATA_W-1:0]  res_c;
  logic               carry_c;

  assign amt_lo        = in_amount[SHAMT_W-1:0];
  assign amt_over      = in_amount[OVER_B];
  assign amt_unused_hi = ^in_amount[AMT_W-1:OVER_B+1];

  sras_barrel #(
    .DATA_W  (DATA_W),
    .SHAMT_W (SHAMT_W)
  ) u_barrel (
    .value    (in_value),
    .amt      (amt_lo),
    .shifted  (shifted),
    .lost_any (lost_any)
  );

  sras_resolve #(
    .DATA_W (DATA_W)
  ) u_resolve (
    .value    (in_value),
    .shifted  (shifted),
    .lost_any (lost_any),
    .over     (amt_over),
    .result   (res_c),
    .carry    (carry_c)
  );

  sras_out_stage #(
    .DATA_W   (DATA_W),
    .OUT_MODE (OUT_MODE)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .res_d      (res_c),
    .carry_d    (carry_c),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_carry  (out_carry)
  );

endmodule

// File: rtl/sras_unit_chk.sv
module sras_unit_chk
  import sras_pkg::*;
#(
  parameter int             DATA_W   = 32,
  parameter int             AMT_W    = 32,
  parameter sras_out_mode_e OUT_MODE = SRAS_OUT_REG
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_value,
  input logic [AMT_W-1:0]  in_amount,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic              out_carry
);

  localparam int SB = $clog2(DATA_W);
  localparam int MSB = DATA_W - 1;

  if (OUT_MODE == SRAS_OUT_REG) begin : g_reg_chk
    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    assert_valid_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    assert_hold_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_result) && $stable(out_carry)));
    assert_zero_amt_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_amount[SB:0] == '0) |=>
        (out_result == $past(in_value) && !out_carry));
    assert_sign_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_result[MSB] == $past(in_value[MSB])));
    assert_pos_no_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_value[MSB]) |=> !out_carry);
    assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_amount[SB]) |=> (out_result == {DATA_W{$past(in_value[MSB])}}));
    assert_sat_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_amount[SB]) |=>
        (out_carry == ($past(in_value[MSB]) && $past(|in_value[MSB-1:0]))));
  end else begin : g_comb_chk
    assert_valid_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid);
    assert_zero_amt_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_amount[SB:0] == '0) |-> (out_result == in_value && !out_carry));
    assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_amount[SB] |-> (out_result == {DATA_W{in_value[MSB]}}));
    assert_pos_no_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_value[MSB] |-> !out_carry);
  end

endmodule

bind sras_unit sras_unit_chk #(
  .DATA_W   (DATA_W),
  .AMT_W    (AMT_W),
  .OUT_MODE (OUT_MODE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_value   (in_value),
  .in_amount  (in_amount),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_carry  (out_carry)
);

// File: tb/sras_unit_tb.sv
module sras_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_value;
  logic [31:0] in_amount;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_carry;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // Reference state: what the outputs must show after the next edge
  logic        exp_valid;
  logic [31:0] exp_res;
  logic        exp_ca;
  string       tag_res, tag_ca;

  sras_unit u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_value   (in_value),
    .in_amount  (in_amount),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_carry  (out_carry)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [32:0] ref_sra(logic [31:0] v, logic [31:0] a);
    int          sh;
    logic [63:0] mask;
    logic [31:0] r;
    logic        c;
    sh = int'(a[5:0]);
    if (sh >= 32) begin
      r = v[31] ? 32'hFFFF_FFFF : 32'h0;
      c = v[31] && (v[30:0] != 0);
    end else begin
      r    = 32'($signed(v) >>> sh);
      mask = (64'd1 << sh) - 64'd1;
      c    = v[31] && ((v & mask[31:0]) != 0);
    end
    return {c, r};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R7", "out_valid", {31'd0, out_valid}, {31'd0, exp_valid});
    check(tag_res, "out_result", out_result, exp_res);
    check(tag_ca, "out_carry", {31'd0, out_carry}, {31'd0, exp_ca});
  endtask

  // Drive one cycle at the falling edge, then compare at the next falling edge
  task automatic step(logic vld, logic [31:0] v, logic [31:0] a);
    logic [32:0] r;
    in_valid  = vld;
    in_value  = v;
    in_amount = a;
    exp_valid = vld;
    if (vld) begin
      r       = ref_sra(v, a);
      exp_res = r[31:0];
      exp_ca  = r[32];
      if (a[31:6] != 0) begin
        tag_res = "R6"; tag_ca = "R6";
      end else if (a[5:0] == 0) begin
        tag_res = "R3"; tag_ca = "R3";
      end else if (a[5]) begin
        tag_res = "R4"; tag_ca = "R5";
      end else begin
        tag_res = "R1"; tag_ca = "R2";
      end
    end else begin
      tag_res = "R8"; tag_ca = "R8";
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_value  = '0;
    in_amount = '0;
    exp_valid = 1'b0;
    exp_res   = '0;
    exp_ca    = 1'b0;
    tag_res   = "R9";
    tag_ca    = "R9";
    repeat (3) @(negedge clk);
    compare_all();                               // R9 reset state
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();                               // R9 still idle after release

    // R3: zero amount
    step(1, 32'h8000_0000, 32'd0);
    step(1, 32'hDEAD_BEEF, 32'd0);
    // R1/R2: in-range shifts
    step(1, 32'hF000_0000, 32'd4);               // negative, no loss -> ca 0
    step(1, 32'hF000_0001, 32'd4);               // negative, loss -> ca 1
    step(1, 32'h7FFF_FFFF, 32'd31);              // positive -> 0, ca 0
    step(1, 32'h8000_0000, 32'd31);              // -> all ones, ca 0
    step(1, 32'h8000_0001, 32'd31);              // ca 1
    step(1, 32'h1234_5678, 32'd8);
    // R4/R5: over-range, meets carry in the same cycle
    step(1, 32'h8000_0000, 32'd32);              // all ones, ca 0
    step(1, 32'h8000_0010, 32'd63);              // all ones, ca 1
    step(1, 32'h1234_5678, 32'd40);              // zero, ca 0
    step(1, 32'h7FFF_FFFF, 32'd63);              // zero, ca 0
    // R6: junk above bit 5
    step(1, 32'hFFFF_FF01, 32'hFFFF_FFC1);       // effective amount 1
    step(1, 32'h8000_0003, 32'hABCD_EF60);       // effective 32
    step(1, 32'h4000_0000, 32'h0000_0040);       // effective 0
    // R8: hold while idle, with changing junk inputs
    step(0, 32'h0000_0000, 32'd63);
    step(0, 32'hFFFF_FFFF, 32'd1);
    step(1, 32'hC000_0000, 32'd30);
    step(0, 32'h1111_1111, 32'd0);
    // Random sweep with mixed valid
    for (int i = 0; i < 400; i++) begin
      logic [31:0] v, a;
      v = $urandom;
      a = $urandom;
      step(($urandom % 4) != 0, v, a);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule